// File: doc/BRIEF.md
# Event Status, Interrupt Vector and DMA Request Unit

This unit keeps the event status word and the interrupt enable mask of a serial-bus controller. The transfer engine reports events as single-cycle set pulses. The unit combines each status bit with its enable to drive one level-sensitive interrupt line. It also drives two DMA request lines, one for the receive direction and one for the transmit direction. Each DMA request line is gated by its own enable bit.

Software reaches the unit through a small register port with separate read and write strobes and a 3-bit register select. Status bits are cleared by writing ones to them, but only a fixed subset of bits can be cleared this way. A vector register offers a faster way to service interrupts. Reading it returns the number of the lowest-numbered pending enabled event and clears that event in the same clock. A self-test write raises the low status bits, so that the interrupt path can be exercised without bus traffic.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the status, mask and DMA enables are zero and the self-test flag is clear. irqOut, rxDmaReq and txDmaReq are low.
- R2: irqOut is high exactly when some status bit and the mask bit with the same index are both set. Mask bits cover status bits 5:0.
- R3: rxDmaReq equals status bit 3 while the receive DMA enable is set, and is low otherwise. txDmaReq equals status bit 4 while the transmit DMA enable is set, and is low otherwise.
- R4: A write to select 3 stores only wrData bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), and reads back with only those bits. Writing bit 15 as one clears mask bit 3, and writing bit 7 as one clears mask bit 4. The other mask bits are left unchanged.
- R5: A write to select 0 loads the mask from wrData[5:0]. A read of select 0 returns the mask with bits 15:6 zero.
- R6: A write to select 1 clears each status bit whose wrData bit is one, but only for bits 0, 1, 2 and 5. All other status bits keep their value.
- R7: A read of select 1 returns the status with bit 12 replaced by busyIn. Status bit 12 is never stored, even when evtSet bit 12 pulses.
- R8: A read of select 2 returns, in the same cycle, the index plus one of the lowest set bit of (status AND mask), or zero when no such bit exists. At the clock edge of that read, only that one status bit is cleared.
- R9: A write to select 4 with wrData bit 15 set raises status bits 5:0 at that edge and sets the self-test flag. A read of select 4 returns the flag in bit 15. A write with bit 15 clear leaves the status unchanged.
- R10: Each evtSet bit that is high at a clock edge sets the matching status bit. When the same bit is also being cleared in that cycle, by a status write or by a vector read, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register select: 0 mask, 1 status, 2 vector, 3 DMA enables, 4 self-test |
| wrData | input | 16 | Write data |
| evtSet | input | 16 | Event set pulses from the transfer engine |
| busyIn | input | 1 | Bus-busy level, shown in status read bit 12 |
| rdData | output | 16 | Read data, valid in the strobe cycle, zero when rdEn is low |
| irqOut | output | 1 | Interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The checker assumes three things about the inputs: rdEn and wrEn are never raised together on the vector select, evtSet bits are pulses sampled at a single edge, and all inputs are stable around the rising clock edge. It models the mask and DMA enables only from the register writes it observes, so it relies on select 0 and select 3 being the only ways to change them. The bench changes every input on the falling edge, issues one access per cycle, and raises evtSet alone or together with a single clearing access. This keeps every stimulus within those assumptions.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int ADDR_W = 3;

  // Register selects; the vector select must stay distinct from status.
  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_STAT = 3'd1,
    SEL_VEC  = 3'd2,
    SEL_DMA  = 3'd3,
    SEL_TEST = 3'd4
  } regSel_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic wrMask;
    logic wrStat;
    logic wrDma;
    logic wrTest;
    logic rdVec;
    logic rdAny;
  } strobes_t;

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strb,
  output regSel_e           rdSel
);

  regSel_e sel;

  always_comb begin
    sel         = regSel_e'(addr);
    strb        = '0;
    strb.wrMask = wrEn && (sel == SEL_MASK);
    strb.wrStat = wrEn && (sel == SEL_STAT);
    strb.wrDma  = wrEn && (sel == SEL_DMA);
    strb.wrTest = wrEn && (sel == SEL_TEST);
    strb.rdVec  = rdEn && (sel == SEL_VEC);
    strb.rdAny  = rdEn;
    rdSel       = sel;
  end

endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          MASK_W      = 6,
  parameter int          BUSY_BIT    = 12,
  parameter int          RX_RDY_BIT  = 3,
  parameter int          TX_RDY_BIT  = 4,
  parameter int          RX_EN_BIT   = 15,
  parameter int          TX_EN_BIT   = 7,
  parameter int          TEST_EN_BIT = 15,
  parameter int          SELF_W      = 6,
  parameter logic [15:0] W1C_BITS    = 16'h0027
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busyIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  localparam int VEC_W = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << BUSY_BIT);
  localparam logic [DATA_W-1:0] SELF_MASK  = DATA_W'((64'd1 << SELF_W) - 64'd1);
  localparam logic [DATA_W-1:0] CLR_ALLOW  = DATA_W'(W1C_BITS);

  logic [DATA_W-1:0] statQ, statD;
  logic [MASK_W-1:0] maskQ;
  logic              rxEnQ, txEnQ, testEnQ;

  logic [DATA_W-1:0] pending;
  logic [DATA_W-1:0] lowOneHot;
  logic [VEC_W-1:0]  hitIdx;
  logic              hit;
  logic [VEC_W-1:0]  vecVal;
  logic [DATA_W-1:0] clrBits, setBits;

  assign pending = statQ & {{(DATA_W-MASK_W){1'b0}}, maskQ};

  // Lowest pending bit isolated as a one-hot word.
  assign lowOneHot = pending & (~pending + DATA_W'(1));

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        hit    = 1'b1;
        hitIdx = VEC_W'(i);
      end
    end
    vecVal = hit ? hitIdx + VEC_W'(1) : '0;
  end

  // Status next state: clears first, engine and self-test sets win.
  always_comb begin
    clrBits = '0;
    if (strb.wrStat) clrBits = clrBits | (wrData & CLR_ALLOW);
    if (strb.rdVec)  clrBits = clrBits | lowOneHot;
    setBits = evtSet;
    if (strb.wrTest && wrData[TEST_EN_BIT]) setBits = setBits | SELF_MASK;
    statD = ((statQ & ~clrBits) | setBits) & STORE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ <= statD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strb.wrMask) begin
      maskQ <= wrData[MASK_W-1:0];
    end else if (strb.wrDma) begin
      if (wrData[RX_EN_BIT]) maskQ[RX_RDY_BIT] <= 1'b0;
      if (wrData[TX_EN_BIT]) maskQ[TX_RDY_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnQ   <= 1'b0;
      txEnQ   <= 1'b0;
      testEnQ <= 1'b0;
    end else begin
      if (strb.wrDma) begin
        rxEnQ <= wrData[RX_EN_BIT];
        txEnQ <= wrData[TX_EN_BIT];
      end
      if (strb.wrTest) testEnQ <= wrData[TEST_EN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdAny) begin
      case (rdSel)
        SEL_MASK: rdData = {{(DATA_W-MASK_W){1'b0}}, maskQ};
        SEL_STAT: rdData = statQ | (DATA_W'(busyIn) << BUSY_BIT);
        SEL_VEC:  rdData = {{(DATA_W-VEC_W){1'b0}}, vecVal};
        SEL_DMA:  rdData = (DATA_W'(rxEnQ) << RX_EN_BIT) | (DATA_W'(txEnQ) << TX_EN_BIT);
        SEL_TEST: rdData = DATA_W'(testEnQ) << TEST_EN_BIT;
        default:  rdData = '0;
      endcase
    end
  end

  assign irqOut   = |pending;
  assign rxDmaReq = statQ[RX_RDY_BIT] & rxEnQ;
  assign txDmaReq = statQ[TX_RDY_BIT] & txEnQ;

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MASK_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busyIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  strobes_t strb;
  regSel_e  rdSel;

  evt_irq_ctrl u_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  evt_irq_datapath #(
    .DATA_W (DATA_W),
    .MASK_W (MASK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (wrData),
    .evtSet   (evtSet),
    .busyIn   (busyIn),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .rxDmaReq (rxDmaReq),
    .txDmaReq (txDmaReq)
  );

endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MASK_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] evtSet,
  input logic              busyIn,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic              rxDmaReq,
  input logic              txDmaReq
);

  logic [MASK_W-1:0] maskSh;
  logic              rxEnSh, txEnSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskSh <= '0;
      rxEnSh <= 1'b0;
      txEnSh <= 1'b0;
    end else if (wrEn && addr == SEL_MASK) begin
      maskSh <= wrData[MASK_W-1:0];
    end else if (wrEn && addr == SEL_DMA) begin
      rxEnSh <= wrData[15];
      txEnSh <= wrData[7];
      if (wrData[15]) maskSh[3] <= 1'b0;
      if (wrData[7])  maskSh[4] <= 1'b0;
    end
  end

  // R2
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskSh == '0) |-> !irqOut);

  // R3
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnSh |-> !rxDmaReq);

  // R3
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnSh |-> !txDmaReq);

  // R5
  mask_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == SEL_MASK) |-> (rdData[DATA_W-1:MASK_W] == '0));

  // R7
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == SEL_STAT) |-> (rdData[12] == busyIn));

  // R8
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == SEL_VEC) |-> ((rdData == '0) == !irqOut));

endmodule

bind evt_irq_unit evt_irq_checker #(
  .DATA_W (DATA_W),
  .MASK_W (MASK_W)
) u_chk (.*);

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] evtSet = '0;
  logic        busyIn = 1'b0;
  logic [15:0] rdData;
  logic        irqOut, rxDmaReq, txDmaReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_unit u_evt_irq_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .evtSet(evtSet), .busyIn(busyIn), .rdData(rdData),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [2:0]  sel;
    logic [15:0] wdat;
    logic [15:0] evt;
    logic        busy;
    logic [15:0] expRd;
    logic        expIrq;
    logic        expRx;
    logic        expTx;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 32;
  // Selects: 0 mask, 1 status, 2 vector, 3 DMA, 4 self-test.
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b0,3'd0,16'h0000,16'h0008,1'b0,16'h0000,1'b0,1'b0,1'b0,4'd10}, // R10 set bit3
    '{1'b1,1'b0,3'd0,16'hFFFF,16'h0000,1'b0,16'h0000,1'b1,1'b0,1'b0,4'd5},  // R5 mask all
    '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b0,16'h003F,1'b1,1'b0,1'b0,4'd5},  // R5 readback
    '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b1,16'h1008,1'b1,1'b0,1'b0,4'd7},  // R7 busy shown
    '{1'b1,1'b0,3'd3,16'hFFFF,16'h0000,1'b0,16'h0000,1'b0,1'b1,1'b0,4'd4},  // R4 both enables
    '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b0,16'h8080,1'b0,1'b1,1'b0,4'd4},  // R4 readback
    '{1'b0,1'b0,3'd0,16'h0000,16'h0010,1'b0,16'h0000,1'b0,1'b1,1'b1,4'd3},  // R3 tx ready
    '{1'b1,1'b0,3'd3,16'h0080,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd3},  // R3 rx gated off
    '{1'b1,1'b0,3'd1,16'hFFFF,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd6},  // R6 w1c ignores 3,4
    '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b0,16'h0018,1'b0,1'b0,1'b1,4'd6},  // R6 status kept
    '{1'b0,1'b0,3'd0,16'h0000,16'h0006,1'b0,16'h0000,1'b1,1'b0,1'b1,4'd10}, // R10 set 1,2
    '{1'b0,1'b1,3'd2,16'h0000,16'h0000,1'b0,16'h0002,1'b1,1'b0,1'b1,4'd8},  // R8 vector bit1
    '{1'b0,1'b1,3'd2,16'h0000,16'h0000,1'b0,16'h0003,1'b0,1'b0,1'b1,4'd8},  // R8 vector bit2
    '{1'b0,1'b1,3'd2,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd8},  // R8 empty
    '{1'b1,1'b0,3'd1,16'h0004,16'h0004,1'b0,16'h0000,1'b1,1'b0,1'b1,4'd10}, // R10 set beats w1c
    '{1'b0,1'b1,3'd2,16'h0000,16'h0004,1'b0,16'h0003,1'b1,1'b0,1'b1,4'd10}, // R10 set beats vector
    '{1'b1,1'b0,3'd1,16'h0004,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd6},  // R6 clear bit2
    '{1'b1,1'b0,3'd4,16'h8000,16'h0000,1'b0,16'h0000,1'b1,1'b0,1'b1,4'd9},  // R9 self-test
    '{1'b0,1'b1,3'd4,16'h0000,16'h0000,1'b0,16'h8000,1'b1,1'b0,1'b1,4'd9},  // R9 flag
    '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b0,16'h003F,1'b1,1'b0,1'b1,4'd9},  // R9 bits 5:0
    '{1'b1,1'b0,3'd0,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd2},  // R2 mask off
    '{1'b0,1'b1,3'd2,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd8},  // R8 none enabled
    '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b0,16'h003F,1'b0,1'b0,1'b1,4'd8},  // R8 status intact
    '{1'b0,1'b0,3'd0,16'h0000,16'h1000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd7},  // R7 pulse bit12
    '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b0,16'h003F,1'b0,1'b0,1'b1,4'd7},  // R7 not stored
    '{1'b1,1'b0,3'd0,16'h0020,16'h0000,1'b0,16'h0000,1'b1,1'b0,1'b1,4'd2},  // R2 bit5 only
    '{1'b0,1'b1,3'd2,16'h0000,16'h0000,1'b0,16'h0006,1'b0,1'b0,1'b1,4'd8},  // R8 vector bit5
    '{1'b1,1'b0,3'd4,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd9},  // R9 flag off
    '{1'b0,1'b1,3'd4,16'h0000,16'h0000,1'b0,16'h0000,1'b0,1'b0,1'b1,4'd9},  // R9 readback
    '{1'b1,1'b0,3'd0,16'h003F,16'h0000,1'b0,16'h0000,1'b1,1'b0,1'b1,4'd2},  // R2 mask all
    '{1'b1,1'b0,3'd3,16'h8000,16'h0000,1'b0,16'h0000,1'b1,1'b1,1'b0,4'd4},  // R4 rx only
    '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b0,16'h0037,1'b1,1'b1,1'b0,4'd4}   // R4 mask bit3 gone
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic r, input logic [2:0] s,
                        input logic [15:0] d, input logic [15:0] e, input logic b,
                        output logic [15:0] rdv);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = s; wrData = d; evtSet = e; busyIn = b;
    #1 rdv = rdData;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0; evtSet = '0; busyIn = 1'b0;
  endtask

  logic [15:0] got;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 outputs", {13'd0, irqOut, rxDmaReq, txDmaReq}, 16'h0000);
    access(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 1'b0, got); chk("R1 status", got, 16'h0000);
    access(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, 1'b0, got); chk("R1 mask", got, 16'h0000);
    access(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, 1'b0, got); chk("R1 dma", got, 16'h0000);
    access(1'b0, 1'b1, 3'd4, 16'h0, 16'h0, 1'b0, got); chk("R1 test", got, 16'h0000);

    // R6 bits 0 and 5 clear individually
    access(1'b0, 1'b0, 3'd0, 16'h0, 16'h0021, 1'b0, got);
    access(1'b1, 1'b0, 3'd1, 16'h0001, 16'h0, 1'b0, got);
    access(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 1'b0, got); chk("R6 bit0 cleared", got, 16'h0020);
    access(1'b1, 1'b0, 3'd1, 16'h0020, 16'h0, 1'b0, got);
    access(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 1'b0, got); chk("R6 bit5 cleared", got, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = TBL[i];
      access(v.wr, v.rd, v.sel, v.wdat, v.evt, v.busy, got);
      chk($sformatf("R%0d step %0d rdData", v.req, i), got, v.expRd);
      chk($sformatf("R%0d step %0d irq/rx/tx", v.req, i),
          {13'd0, irqOut, rxDmaReq, txDmaReq}, {13'd0, v.expIrq, v.expRx, v.expTx});
    end
    idle();

    // R1 reset in mid-run clears pending interrupt and requests
    @(negedge clk) rstN = 1'b0;
    #1 chk("R1 async reset outputs", {13'd0, irqOut, rxDmaReq, txDmaReq}, 16'h0000);
    @(negedge clk) rstN = 1'b1;
    access(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 1'b0, got); chk("R1 status after reset", got, 16'h0000);
    access(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, 1'b0, got); chk("R1 mask after reset", got, 16'h0000);
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule